// File: doc/BRIEF.md
# Wide Integer Multiplier with Rotating Half-Word Schedule

This block forms the full double-width product of two unsigned multi-word operands. Each operand is cut into 16-bit half-words. A row of 2N small multiply-accumulate lanes receives one half-word of the second operand per cycle, together with a rotated selection of half-words from the first operand. The lanes produce 4N-1 partial sums, each 48 bits wide. A folding stage then merges those partial sums into 2N product words of 32 bits. It uses a 16-bit carry that moves from one word to the next.

A caller presents both operands and pulses `start_i` for one cycle. Both operands are captured in that cycle. After exactly 4N clock cycles, `done_o` pulses for one cycle and `prod_o` carries the complete product, least significant word in bits 31:0. The product stays on `prod_o` until the folding phase of a later operation rewrites it.

Control is a four-state machine. `ST_IDLE` waits for a start. `ST_MULT` runs 2N multiply cycles, with the cycle index in a counter. `ST_FOLD` runs 2N folding cycles. `ST_DONE` lasts one cycle and raises `done_o`. The transitions are:
- idle-to-mult, taken on a start in `ST_IDLE`.
- mult-to-fold, taken after the last multiply cycle.
- fold-to-done, taken after the last folding cycle.
- done-to-mult, taken on a start in `ST_DONE`.
- done-to-idle, taken otherwise.

Top module: `wide_mul_pp`

## Requirements
- R1: Operand word w supplies half-word index 2w from its bits 15:0 and half-word index 2w+1 from its bits 31:16. In multiply cycle t, every lane receives the second operand's half-word 2N-1-t. Lane x multiplies it by the first operand's half-word (t-x) mod 2N.
- R2: `prod_o` equals the unsigned product of `a_i` and `b_i` as captured at the accepted start. Product word k sits in bits 32k+31:32k, least significant word first.
- R3: If either operand is zero, the product is all zeros.
- R4: With all-ones operands, the result is exact, including the carries into the most significant word.
- R5: `done_o` is high for exactly one cycle. That cycle is the 4N-th clock edge after the edge that accepted the start.
- R6: A start pulse in `ST_MULT` or `ST_FOLD` is ignored. The result, the operands in use and the completion time all stay those of the running operation.
- R7: `prod_o` changes only on folding-cycle edges. It holds its value from `done_o` until the next operation folds.
- R8: While reset is asserted, `done_o` is low and `prod_o` is all zeros.
- R9: A start in the `done_o` cycle is accepted. It begins a new operation with fresh operands and the full 4N-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a multiplication |
| a_i | input | N_WORDS*WORD_W | First operand, sampled with an accepted start |
| b_i | input | N_WORDS*WORD_W | Second operand, sampled with an accepted start |
| done_o | output | 1 | One-cycle pulse: product complete |
| prod_o | output | 2*N_WORDS*WORD_W | Full product, least significant word lowest |

## Verification
Two events can land in the same cycle: the completion pulse of one operation and the start request of the next. The bench raises a new start with new operands while it is still sampling `done_o`. It then checks two things: the earlier product was intact in that cycle, and the new result arrives with full latency and correct value. It also issues a second start, with different operand values on the inputs, in the middle of the multiply phase. That run is judged on whether the finished product and its completion cycle still belong to the first request.

// File: rtl/wide_mul_pkg.sv
package wide_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_FOLD = 2'd2,
        ST_DONE = 2'd3
    } wm_state_e;
endpackage

// File: rtl/wide_mul_ctrl.sv
module wide_mul_ctrl
    import wide_mul_pkg::*;
#(
    parameter int N_HALF = 16,
    localparam int CNT_W = $clog2(N_HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output wm_state_e        st_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o,
    output logic             mac_step_o,
    output logic             fold_step_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

    wm_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d  = ST_MULT;
                    cnt_d = '0;
                end
            end
            ST_MULT: begin
                if (cnt_q == LAST) begin
                    st_d  = ST_FOLD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FOLD: begin
                if (cnt_q == LAST) begin
                    st_d  = ST_DONE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                cnt_d = '0;
                st_d  = start_i ? ST_MULT : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o      = 1'b0;
        mac_step_o  = 1'b0;
        fold_step_o = 1'b0;
        done_o      = 1'b0;
        unique case (st_q)
            ST_IDLE: load_o = start_i;
            ST_MULT: mac_step_o = 1'b1;
            ST_FOLD: fold_step_o = 1'b1;
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    assign st_o  = st_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/wide_mul_mac_array.sv
module wide_mul_mac_array #(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W = WORD_W / 2,
    localparam int N_HALF = 2 * N_WORDS,
    localparam int ACC_W  = WORD_W + HALF_W,
    localparam int CNT_W  = $clog2(N_HALF),
    localparam int OP_W   = N_WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] t_i,
    input  logic [CNT_W-1:0] rd_w_i,
    output logic [ACC_W-1:0] pw_lo_o,
    output logic [ACC_W-1:0] pw_mid_o,
    output logic [ACC_W-1:0] pw_hi_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

    logic [OP_W-1:0]   a_q, b_q;
    logic [HALF_W-1:0] a_h [N_HALF];
    logic [HALF_W-1:0] b_h [N_HALF];
    logic [ACC_W-1:0]  mac_q [N_HALF];
    logic [ACC_W-1:0]  upper_q [N_HALF-1];
    logic [ACC_W-1:0]  pw_all [2*N_HALF];
    logic [HALF_W-1:0] b_bcast;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load_i) begin
            a_q <= a_i;
            b_q <= b_i;
        end
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_split
        assign a_h[h] = a_q[h*HALF_W +: HALF_W];
        assign b_h[h] = b_q[h*HALF_W +: HALF_W];
    end

    assign b_bcast = b_h[LAST - t_i];

    for (genvar x = 0; x < N_HALF; x++) begin : g_lane
        logic [CNT_W-1:0]    a_idx;
        logic [2*HALF_W-1:0] prod;
        logic [ACC_W-1:0]    prod_ext;

        always_comb begin
            int k;
            k = int'(t_i) - x;
            if (k < 0) k = k + N_HALF;
            a_idx = k[CNT_W-1:0];
        end

        assign prod     = a_h[a_idx] * b_bcast;
        assign prod_ext = {{(ACC_W-2*HALF_W){1'b0}}, prod};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mac_q[x] <= '0;
            end else if (load_i) begin
                mac_q[x] <= '0;
            end else if (step_i) begin
                if ((x != 0) && (t_i == CNT_W'(x))) mac_q[x] <= prod_ext;
                else                                 mac_q[x] <= mac_q[x] + prod_ext;
            end
        end
    end

    // upper partial words, one captured per multiply cycle t > 0
    for (genvar j = 0; j < N_HALF - 1; j++) begin : g_upper
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                upper_q[j] <= '0;
            else if (step_i && (t_i == CNT_W'(N_HALF - 1 - j)))
                upper_q[j] <= mac_q[N_HALF - 1 - j];
        end
    end

    // flat view of all partial words; last slot is a zero pad
    for (genvar i = 0; i < N_HALF; i++) begin : g_pw_lo
        assign pw_all[i] = mac_q[N_HALF - 1 - i];
    end
    for (genvar j = 0; j < N_HALF - 1; j++) begin : g_pw_hi
        assign pw_all[N_HALF + j] = upper_q[j];
    end
    assign pw_all[2*N_HALF-1] = '0;

    logic [CNT_W:0] idx_mid, idx_hi, idx_lo;
    assign idx_mid  = {rd_w_i, 1'b0};
    assign idx_hi   = {rd_w_i, 1'b1};
    assign idx_lo   = idx_mid - 1'b1;
    assign pw_mid_o = pw_all[idx_mid];
    assign pw_hi_o  = pw_all[idx_hi];
    assign pw_lo_o  = pw_all[idx_lo];
endmodule

// File: rtl/wide_mul_fold.sv
module wide_mul_fold #(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W = WORD_W / 2,
    localparam int N_HALF = 2 * N_WORDS,
    localparam int ACC_W  = WORD_W + HALF_W,
    localparam int CNT_W  = $clog2(N_HALF),
    localparam int PR_W   = N_HALF * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] w_i,
    input  logic [ACC_W-1:0] pw_lo_i,
    input  logic [ACC_W-1:0] pw_mid_i,
    input  logic [ACC_W-1:0] pw_hi_i,
    output logic [PR_W-1:0]  prod_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

    logic [HALF_W-1:0] carry_q;
    logic [WORD_W-1:0] word_q [N_HALF];
    logic              first, last;
    logic [ACC_W-1:0]  lo_part, hi_part, carry_ext, sum0, sum1;

    assign first     = (w_i == '0);
    assign last      = (w_i == LAST);
    assign lo_part   = first ? '0 : (pw_lo_i >> HALF_W);
    assign hi_part   = last ? '0 : {{HALF_W{1'b0}}, pw_hi_i[HALF_W-1:0], {HALF_W{1'b0}}};
    assign carry_ext = {{WORD_W{1'b0}}, carry_q};
    assign sum0      = pw_mid_i + lo_part;
    assign sum1      = sum0 + (hi_part | carry_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       carry_q <= '0;
        else if (clear_i) carry_q <= '0;
        else if (step_i)  carry_q <= sum1[ACC_W-1:WORD_W];
    end

    for (genvar k = 0; k < N_HALF; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[k] <= '0;
            else if (step_i && (w_i == CNT_W'(k)))
                word_q[k] <= sum1[WORD_W-1:0];
        end
        assign prod_o[k*WORD_W +: WORD_W] = word_q[k];
    end
endmodule

// File: rtl/wide_mul_pp.sv
module wide_mul_pp
    import wide_mul_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 32,
    localparam int HALF_W = WORD_W / 2,
    localparam int N_HALF = 2 * N_WORDS,
    localparam int ACC_W  = WORD_W + HALF_W,
    localparam int CNT_W  = $clog2(N_HALF),
    localparam int OP_W   = N_WORDS * WORD_W,
    localparam int PR_W   = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    output logic            done_o,
    output logic [PR_W-1:0] prod_o
);
    wm_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic             load, mac_step, fold_step;
    logic [ACC_W-1:0] pw_lo, pw_mid, pw_hi;

    wide_mul_ctrl #(.N_HALF(N_HALF)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .st_o        (st),
        .cnt_o       (cnt),
        .load_o      (load),
        .mac_step_o  (mac_step),
        .fold_step_o (fold_step),
        .done_o      (done_o)
    );

    wide_mul_mac_array #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .a_i      (a_i),
        .b_i      (b_i),
        .step_i   (mac_step),
        .t_i      (cnt),
        .rd_w_i   (cnt),
        .pw_lo_o  (pw_lo),
        .pw_mid_o (pw_mid),
        .pw_hi_o  (pw_hi)
    );

    wide_mul_fold #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .step_i   (fold_step),
        .w_i      (cnt),
        .pw_lo_i  (pw_lo),
        .pw_mid_i (pw_mid),
        .pw_hi_i  (pw_hi),
        .prod_o   (prod_o)
    );
endmodule

// File: rtl/wide_mul_pp_chk.sv
module wide_mul_pp_chk
    import wide_mul_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 32,
    localparam int N_HALF = 2 * N_WORDS,
    localparam int CNT_W  = $clog2(N_HALF),
    localparam int PR_W   = 2 * N_WORDS * WORD_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            done_o,
    input logic [PR_W-1:0] prod_o,
    input wm_state_e       st,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_FOLD_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FOLD && cnt == LAST) |=> done_o); // R5

    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_FOLD) |=> $stable(prod_o)); // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MULT && cnt != LAST && start_i) |=> (st == ST_MULT && cnt == $past(cnt) + 1'b1)); // R6

    AST_DONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (st == ST_MULT && cnt == '0)); // R9
endmodule

bind wide_mul_pp wide_mul_pp_chk #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .prod_o  (prod_o),
    .st      (st),
    .cnt     (cnt)
);

// File: tb/test_wide_mul_pp.sv
module test_wide_mul_pp;
    localparam int N    = 8;
    localparam int W    = 32;
    localparam int OPW  = N * W;
    localparam int PRW  = 2 * OPW;
    localparam int LAT  = 4 * N;
    localparam int NVEC = 6;

    localparam logic [OPW-1:0] VA [NVEC] = '{
        {OPW{1'b0}},
        {OPW{1'b1}},
        (256'd1 << 16),
        {8{32'h0001_FFFF}},
        {4{64'h0123_4567_89AB_CDEF}},
        {8{32'hDEAD_BEEF}}
    };
    localparam logic [OPW-1:0] VB [NVEC] = '{
        {8{32'h1234_5678}},
        {OPW{1'b1}},
        (256'd1 << 255),
        {OPW{1'b1}},
        {4{64'hFEDC_BA98_7654_3210}},
        {OPW{1'b0}}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [OPW-1:0] a_i = '0;
    logic [OPW-1:0] b_i = '0;
    logic           done_o;
    logic [PRW-1:0] prod_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wide_mul_pp i_wide_mul_pp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .done_o  (done_o),
        .prod_o  (prod_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [PRW-1:0] ref_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        logic [PRW-1:0] ax, bx;
        ax = {{OPW{1'b0}}, a};
        bx = {{OPW{1'b0}}, b};
        return ax * bx;
    endfunction

    task automatic chk_prod(input string req, input logic [PRW-1:0] got, input logic [PRW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s product: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_int(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // caller is at a negedge; drives a start, returns at negedge of done cycle
    task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                          output logic [PRW-1:0] res, output int lat);
        a_i = a;
        b_i = b;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done_o) break;
        end
        res = prod_o;
    endtask

    initial begin
        logic [PRW-1:0] res, hold;
        logic [OPW-1:0] a0, b0;
        int lat;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk_int("R8 done during reset", int'(done_o), 0);
        chk_prod("R8 reset", prod_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            run_op(VA[v], VB[v], res, lat);
            chk_prod($sformatf("R2 vec%0d (R1 R3 R4)", v), res, ref_mul(VA[v], VB[v]));
            chk_int($sformatf("R5 latency vec%0d", v), lat, LAT);
        end

        // R5 and R7: done falls, product held afterwards
        @(negedge clk);
        chk_int("R5 done single cycle", int'(done_o), 0);
        hold = prod_o;
        a_i = '1;
        b_i = '1;
        repeat (5) @(negedge clk);
        chk_prod("R7 hold after done", prod_o, hold);

        // R6: start in mid-run is ignored
        a0 = {8{32'h8000_0001}};
        b0 = {8{32'h7FFF_FFFF}};
        a_i = a0;
        b_i = b0;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (4) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        a_i = {OPW{1'b1}};
        b_i = 256'd3;
        start_i = 1'b1;
        @(posedge clk);
        lat++;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done_o) break;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk_prod("R6 busy start ignored", prod_o, ref_mul(a0, b0));
        chk_int("R6 latency unchanged", lat, LAT);

        // R9: start in the done cycle
        run_op({8{32'hCAFE_F00D}}, {8{32'h0BAD_1DEA}}, res, lat);
        chk_prod("R9 prior result in done cycle", res, ref_mul({8{32'hCAFE_F00D}}, {8{32'h0BAD_1DEA}}));
        run_op(256'd12345, {OPW{1'b1}}, res, lat);
        chk_prod("R9 back-to-back", res, ref_mul(256'd12345, {OPW{1'b1}}));
        chk_int("R9 back-to-back latency", lat, LAT);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule